// File: doc/BRIEF.md
# Endpoint Buffer CPU Access Port

This block gives a host processor word-wide access to the packet buffers of a USB device controller. There are six buffers, one per endpoint, each 64 bytes long. Each buffer has its own read pointer, write pointer, received length and remaining-byte count. A single control word sets four things: which endpoint the data port reaches, whether the data port moves one byte or two bytes per access, the byte order of two-byte accesses, and how the remaining-byte count behaves while the processor drains a receive buffer. Writing the control word can also carry a one-shot rewind. On a receive buffer the rewind returns the read pointer to the start. On a transmit buffer it returns the write pointer to the start.

The processor side is a plain register bus: a write strobe, a read strobe and a one-bit address that picks the control word or the data port. Read data is combinational while the read strobe is high. Side effects of a read happen at the clock edge that ends the access. The bus has no back-pressure: every access completes in one cycle. A data access that cannot move bytes (empty buffer, full buffer, wrong direction or invalid endpoint) completes with no effect. A side port loads receive bytes and lengths, and reads any buffer byte back. Each endpoint's direction comes in on a static input.

Top module: `ep_cpu_port`

## Requirements
- R1: The control word has read-count mode at bit 15, rewind at bit 12, swap at bit 7, byte-port mode at bit 6 and endpoint code at bits 3:0. Its reset value is 0x0000. Reading it returns the stored fields, with zero in bit 12 and in every other bit.
- R2: Endpoint codes 1 to 6 select endpoints 1 to 6. While any other code is selected, data reads return 0, data writes change nothing and `data_len` is 0.
- R3: With byte-port mode 1, each data access moves one byte. The byte is placed in bits 7:0, and bits 15:8 read as zero.
- R4: With byte-port mode 0 and swap 0, the first buffer byte is in bits 7:0 and the next is in bits 15:8. With swap 1 the two lanes are exchanged. This applies to both reads and writes.
- R5: With read-count mode 0, `data_len` keeps the received length during reads and becomes 0 at the read that takes the last received byte.
- R6: With read-count mode 1, each data read lowers `data_len` by 1 in byte-port mode and by 2 in two-byte mode.
- R7: In two-byte mode with one received byte left, a read returns that byte in bits 7:0 with bits 15:8 zero, and `data_len` goes to 0.
- R8: A data read while `data_len` is 0 returns 0, and `data_len` stays 0.
- R9: A control write with bit 12 set and a receive endpoint code moves that endpoint's read pointer to byte 0 and reloads its count with the received length. A control write with bit 12 clear leaves the pointer and count as they are.
- R10: A control write with bit 12 set and a transmit endpoint code moves that endpoint's write pointer to byte 0 and sets its count to 0.
- R11: Data writes to a transmit endpoint store bytes at its write pointer, and `data_len` gives the bytes written, up to a limit of 64. When the buffer is full, further writes are dropped. Data writes to a receive endpoint are ignored, and data reads from a transmit endpoint return 0.
- R12: Changing the selected endpoint leaves every endpoint's pointers and counts untouched.
- R13: `side_wr` stores one byte at `side_addr`. `side_len_wr` sets the length and count and clears the read pointer. `side_rdata` shows the addressed byte combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_dir_in | input | 6 | Bit i set: endpoint i+1 is a transmit (IN) buffer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 selects the control word, 1 selects the data port |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid while reg_rd is high |
| data_len | output | 7 | Count for the selected endpoint |
| side_wr | input | 1 | Side byte write |
| side_len_wr | input | 1 | Side length load |
| side_ep | input | 4 | Side port endpoint code (1 to 6) |
| side_addr | input | 6 | Side port byte address |
| side_wdata | input | 8 | Side port write byte |
| side_len | input | 7 | Length value for side_len_wr |
| side_rdata | output | 8 | Byte at side_ep and side_addr |

## Verification
The random trials drain receive buffers of random length, up to 64 bytes. Each trial picks a random combination of port width, swap and count mode. An odd length ends a two-byte drain on a single trailing byte, which separates the partial-word rule from the full-word path. Running both count modes over the same drain separates a count that is held and then cleared from a count that steps down. Directed cases cover the remaining rules: an invalid endpoint code, rewinds with bit 12 set and with bit 12 clear on both directions, switching between endpoints partway through a drain, and filling a transmit buffer until further writes are dropped.

// File: rtl/ep_port_pkg.sv
package ep_port_pkg;
  localparam int CTRL_RCNT_BIT = 15;
  localparam int CTRL_REW_BIT  = 12;
  localparam int CTRL_SWAP_BIT = 7;
  localparam int CTRL_BYTE_BIT = 6;

  typedef struct packed {
    logic       rcnt;
    logic       swap;
    logic       byte_mode;
    logic [3:0] ep;
  } port_cfg_t;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_DATA = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/ep_ctrl_reg.sv
module ep_ctrl_reg
  import ep_port_pkg::*;
#(
  parameter int NUM_EP = 6,
  localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [15:0]      wdata,
  output port_cfg_t        cfg,
  output logic             sel_ok,
  output logic [IDX_W-1:0] sel_idx,
  output logic             rew_req,
  output logic [IDX_W-1:0] rew_idx,
  output logic [15:0]      ctrl_word
);
  function automatic logic code_ok(input logic [3:0] c);
    return (c != 4'd0) && (int'(c) <= NUM_EP);
  endfunction

  function automatic logic [IDX_W-1:0] code_idx(input logic [3:0] c);
    logic [3:0] t;
    t = c - 4'd1;
    return t[IDX_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr) begin
      cfg.rcnt      <= wdata[CTRL_RCNT_BIT];
      cfg.swap      <= wdata[CTRL_SWAP_BIT];
      cfg.byte_mode <= wdata[CTRL_BYTE_BIT];
      cfg.ep        <= wdata[3:0];
    end
  end

  always_comb begin
    sel_ok    = code_ok(cfg.ep);
    sel_idx   = sel_ok ? code_idx(cfg.ep) : '0;
    rew_req   = wr && wdata[CTRL_REW_BIT] && code_ok(wdata[3:0]);
    rew_idx   = code_ok(wdata[3:0]) ? code_idx(wdata[3:0]) : '0;
    ctrl_word = '0;
    ctrl_word[CTRL_RCNT_BIT] = cfg.rcnt;
    ctrl_word[CTRL_SWAP_BIT] = cfg.swap;
    ctrl_word[CTRL_BYTE_BIT] = cfg.byte_mode;
    ctrl_word[3:0]           = cfg.ep;
  end

  p_rew_valid_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rew_req |-> (wdata[3:0] != 4'd0) && wr);
  p_ctrl_bit12_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ctrl_word[CTRL_REW_BIT] == 1'b0) && (ctrl_word[3:0] == $past(wdata[3:0])));
endmodule

// File: rtl/ep_lane_fmt.sv
module ep_lane_fmt (
  input  logic        byte_mode,
  input  logic        swap,
  input  logic [1:0]  rd_n,
  input  logic [7:0]  rb0,
  input  logic [7:0]  rb1,
  input  logic [15:0] wdata,
  output logic [15:0] rword,
  output logic [7:0]  wb0,
  output logic [7:0]  wb1
);
  always_comb begin
    if (byte_mode || rd_n != 2'd2) rword = {8'h00, rb0};
    else if (swap)                 rword = {rb0, rb1};
    else                           rword = {rb1, rb0};
    if (!byte_mode && swap) begin
      wb0 = wdata[15:8];
      wb1 = wdata[7:0];
    end else begin
      wb0 = wdata[7:0];
      wb1 = wdata[15:8];
    end
  end
endmodule

// File: rtl/ep_buf_bank.sv
module ep_buf_bank #(
  parameter int NUM_EP    = 6,
  parameter int BUF_BYTES = 64,
  localparam int IDX_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int ADDR_W = $clog2(BUF_BYTES),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] dir_in,
  input  logic              sel_ok,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              wide,
  input  logic              rcnt_mode,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [7:0]        wb0,
  input  logic [7:0]        wb1,
  input  logic              rew_req,
  input  logic [IDX_W-1:0]  rew_idx,
  input  logic              side_ok,
  input  logic [IDX_W-1:0]  side_idx,
  input  logic              side_wr,
  input  logic [ADDR_W-1:0] side_addr,
  input  logic [7:0]        side_wdata,
  input  logic              side_len_wr,
  input  logic [PTR_W-1:0]  side_len,
  output logic [7:0]        side_rdata,
  output logic [7:0]        rb0,
  output logic [7:0]        rb1,
  output logic [1:0]        rd_n,
  output logic [PTR_W-1:0]  cnt_sel
);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(BUF_BYTES);

  logic [7:0]       mem   [NUM_EP][BUF_BYTES];
  logic [PTR_W-1:0] rdptr [NUM_EP];
  logic [PTR_W-1:0] wrptr [NUM_EP];
  logic [PTR_W-1:0] len   [NUM_EP];
  logic [PTR_W-1:0] cnt   [NUM_EP];

  logic [PTR_W-1:0]  cur_rd, cur_wr, cur_len, avail, room, want;
  logic [1:0]        wr_n;
  logic [ADDR_W-1:0] ra0, ra1, wa0, wa1;

  always_comb begin
    cur_rd  = rdptr[sel_idx];
    cur_wr  = wrptr[sel_idx];
    cur_len = len[sel_idx];
    cnt_sel = sel_ok ? cnt[sel_idx] : '0;
    avail   = cur_len - cur_rd;
    room    = FULL - cur_wr;
    want    = wide ? PTR_W'(2) : PTR_W'(1);
    rd_n = 2'd0;
    if (rd_req && sel_ok && !dir_in[sel_idx] && cnt_sel != '0 && avail != '0)
      rd_n = (avail < want) ? avail[1:0] : want[1:0];
    wr_n = 2'd0;
    if (wr_req && sel_ok && dir_in[sel_idx] && room != '0)
      wr_n = (room < want) ? room[1:0] : want[1:0];
    ra0 = cur_rd[ADDR_W-1:0];
    ra1 = ra0 + ADDR_W'(1);
    wa0 = cur_wr[ADDR_W-1:0];
    wa1 = wa0 + ADDR_W'(1);
    rb0 = (rd_n != 2'd0) ? mem[sel_idx][ra0] : 8'h00;
    rb1 = (rd_n == 2'd2) ? mem[sel_idx][ra1] : 8'h00;
    side_rdata = side_ok ? mem[side_idx][side_addr] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (side_wr && side_ok) mem[side_idx][side_addr] <= side_wdata;
    if (wr_n != 2'd0) mem[sel_idx][wa0] <= wb0;
    if (wr_n == 2'd2) mem[sel_idx][wa1] <= wb1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_EP; e++) begin
        rdptr[e] <= '0;
        wrptr[e] <= '0;
        len[e]   <= '0;
        cnt[e]   <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_EP; e++) begin
        if (side_len_wr && side_ok && int'(side_idx) == e) begin
          len[e]   <= side_len;
          cnt[e]   <= side_len;
          rdptr[e] <= '0;
        end else if (rew_req && int'(rew_idx) == e) begin
          if (dir_in[e]) begin
            wrptr[e] <= '0;
            cnt[e]   <= '0;
          end else begin
            rdptr[e] <= '0;
            cnt[e]   <= len[e];
          end
        end else if (sel_ok && int'(sel_idx) == e) begin
          if (rd_n != 2'd0) begin
            rdptr[e] <= rdptr[e] + PTR_W'(rd_n);
            if (rcnt_mode)
              cnt[e] <= (cnt[e] > PTR_W'(rd_n)) ? cnt[e] - PTR_W'(rd_n) : '0;
            else if (rdptr[e] + PTR_W'(rd_n) >= len[e])
              cnt[e] <= '0;
          end
          if (wr_n != 2'd0) begin
            wrptr[e] <= wrptr[e] + PTR_W'(wr_n);
            cnt[e]   <= wrptr[e] + PTR_W'(wr_n);
          end
        end
      end
    end
  end

  p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n != 2'd0 && rcnt_mode && !side_len_wr && cnt_sel >= PTR_W'(rd_n))
    |=> cnt_sel == $past(cnt_sel) - PTR_W'($past(rd_n)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n != 2'd0 && !rcnt_mode && !side_len_wr && cur_rd + PTR_W'(rd_n) < cur_len)
    |=> $stable(cnt_sel));
  p_clear_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n != 2'd0 && !rcnt_mode && !side_len_wr && cur_rd + PTR_W'(rd_n) >= cur_len)
    |=> cnt_sel == '0);
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cnt_sel == '0) |-> (rd_n == 2'd0 && rb0 == 8'h00 && rb1 == 8'h00));
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok |-> cur_wr <= FULL);
  p_rewind_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rew_req && !dir_in[rew_idx] && !side_len_wr) |=> rdptr[$past(rew_idx)] == '0);
endmodule

// File: rtl/ep_cpu_port.sv
module ep_cpu_port
  import ep_port_pkg::*;
#(
  parameter int NUM_EP    = 6,
  parameter int BUF_BYTES = 64,
  localparam int IDX_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int ADDR_W = $clog2(BUF_BYTES),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_dir_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [PTR_W-1:0]  data_len,
  input  logic              side_wr,
  input  logic              side_len_wr,
  input  logic [3:0]        side_ep,
  input  logic [ADDR_W-1:0] side_addr,
  input  logic [7:0]        side_wdata,
  input  logic [PTR_W-1:0]  side_len,
  output logic [7:0]        side_rdata
);
  port_cfg_t        cfg;
  logic             sel_ok, rew_req, side_ok;
  logic [IDX_W-1:0] sel_idx, rew_idx, side_idx;
  logic [15:0]      ctrl_word, rword;
  logic [7:0]       rb0, rb1, wb0, wb1;
  logic [1:0]       rd_n;
  logic             ctrl_wr, data_rd, data_wr;
  logic [3:0]       side_t;

  always_comb begin
    ctrl_wr  = reg_wr && reg_addr == ADDR_CTRL;
    data_wr  = reg_wr && reg_addr == ADDR_DATA;
    data_rd  = reg_rd && reg_addr == ADDR_DATA;
    side_ok  = side_ep != 4'd0 && int'(side_ep) <= NUM_EP;
    side_t   = side_ep - 4'd1;
    side_idx = side_ok ? side_t[IDX_W-1:0] : '0;
  end

  ep_ctrl_reg #(.NUM_EP(NUM_EP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(reg_wdata), .cfg(cfg),
    .sel_ok(sel_ok), .sel_idx(sel_idx), .rew_req(rew_req), .rew_idx(rew_idx),
    .ctrl_word(ctrl_word)
  );

  ep_buf_bank #(.NUM_EP(NUM_EP), .BUF_BYTES(BUF_BYTES)) u_bank (
    .clk(clk), .rst_n(rst_n), .dir_in(ep_dir_in), .sel_ok(sel_ok), .sel_idx(sel_idx),
    .wide(!cfg.byte_mode), .rcnt_mode(cfg.rcnt), .rd_req(data_rd), .wr_req(data_wr),
    .wb0(wb0), .wb1(wb1), .rew_req(rew_req), .rew_idx(rew_idx),
    .side_ok(side_ok), .side_idx(side_idx), .side_wr(side_wr), .side_addr(side_addr),
    .side_wdata(side_wdata), .side_len_wr(side_len_wr), .side_len(side_len),
    .side_rdata(side_rdata), .rb0(rb0), .rb1(rb1), .rd_n(rd_n), .cnt_sel(data_len)
  );

  ep_lane_fmt u_fmt (
    .byte_mode(cfg.byte_mode), .swap(cfg.swap), .rd_n(rd_n), .rb0(rb0), .rb1(rb1),
    .wdata(reg_wdata), .rword(rword), .wb0(wb0), .wb1(wb1)
  );

  always_comb begin
    if (!reg_rd)                    reg_rdata = '0;
    else if (reg_addr == ADDR_CTRL) reg_rdata = ctrl_word;
    else                            reg_rdata = rword;
  end

  p_bad_ep_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !sel_ok) |-> (reg_rdata == 16'h0 && data_len == '0));
  p_byte_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && cfg.byte_mode) |-> reg_rdata[15:8] == 8'h00);
endmodule

// File: tb/ep_cpu_port_test.sv
`timescale 1ns/1ps
module ep_cpu_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ep_dir_in = 6'b110000;
  logic        reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [6:0]  data_len;
  logic        side_wr = 0, side_len_wr = 0;
  logic [3:0]  side_ep = 0;
  logic [5:0]  side_addr = 0;
  logic [7:0]  side_wdata = 0, side_rdata;
  logic [6:0]  side_len = 0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mb [1:6][64];

  always #10 clk = ~clk;

  ep_cpu_port uut (
    .clk(clk), .rst_n(rst_n), .ep_dir_in(ep_dir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_len(data_len),
    .side_wr(side_wr), .side_len_wr(side_len_wr), .side_ep(side_ep), .side_addr(side_addr),
    .side_wdata(side_wdata), .side_len(side_len), .side_rdata(side_rdata)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] ctrl_val(input bit rcnt, input bit rew, input bit swp,
                                          input bit oct, input logic [3:0] ep);
    return {rcnt, 2'b00, rew, 4'b0000, swp, oct, 2'b00, ep};
  endfunction

  function automatic logic [15:0] exp_word(input int ep, input int ptr, input int len,
                                           input bit oct, input bit swp);
    if (ptr >= len) return 16'h0;
    if (oct || len - ptr == 1) return {8'h00, mb[ep][ptr]};
    if (swp) return {mb[ep][ptr], mb[ep][ptr+1]};
    return {mb[ep][ptr+1], mb[ep][ptr]};
  endfunction

  task automatic ctrl_wr(input logic [15:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = v;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic ctrl_rd(output logic [15:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = 0; #5 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic data_rd(output logic [15:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = 1; #5 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic data_wr(input logic [15:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = 1; reg_wdata = v;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic side_byte(input int ep, input int a, input logic [7:0] d);
    @(negedge clk); side_wr = 1; side_ep = 4'(ep); side_addr = 6'(a); side_wdata = d;
    mb[ep][a] = d;
    @(posedge clk); #1 side_wr = 0;
  endtask

  task automatic side_setlen(input int ep, input int l);
    @(negedge clk); side_len_wr = 1; side_ep = 4'(ep); side_len = 7'(l);
    @(posedge clk); #1 side_len_wr = 0;
  endtask

  task automatic side_peek(input int ep, input int a, output logic [7:0] d);
    @(negedge clk); side_ep = 4'(ep); side_addr = 6'(a); #2 d = side_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  b;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    ctrl_rd(d); chk("R1 reset ctrl", d, 16'h0000);
    chk("R2 reset data_len", 16'(data_len), 16'h0);

    // R1 / R2: field layout and invalid endpoint code
    ctrl_wr(16'hFFFF); ctrl_rd(d); chk("R1 readback", d, 16'h80CF);
    data_rd(d); chk("R2 invalid ep read", d, 16'h0);
    chk("R2 invalid ep len", 16'(data_len), 16'h0);

    // R13 / R9: rewind on receive buffer
    for (int i = 0; i < 6; i++) side_byte(2, i, 8'(8'h10 + i));
    side_setlen(2, 6);
    side_peek(2, 3, b); chk("R13 side peek", 16'(b), 16'h0013);
    ctrl_wr(ctrl_val(1, 0, 0, 0, 4'd2));
    chk("R13 len loaded", 16'(data_len), 16'd6);
    data_rd(d); chk("R4 little word", d, 16'h1110);
    ctrl_wr(ctrl_val(1, 0, 0, 0, 4'd2));
    chk("R9 bit12 clear keeps count", 16'(data_len), 16'd4);
    data_rd(d); chk("R9 bit12 clear keeps pointer", d, 16'h1312);
    ctrl_wr(ctrl_val(1, 1, 0, 0, 4'd2));
    ctrl_rd(d); chk("R1 rewind reads zero", d, 16'h8002);
    chk("R9 count reloaded", 16'(data_len), 16'd6);
    data_rd(d); chk("R9 reread first word", d, 16'h1110);

    // R12: independence across selection
    for (int i = 0; i < 4; i++) side_byte(1, i, 8'(8'hA0 + i));
    side_setlen(1, 4);
    for (int i = 0; i < 4; i++) side_byte(3, i, 8'(8'hC0 + i));
    side_setlen(3, 4);
    ctrl_wr(ctrl_val(1, 0, 0, 0, 4'd1)); data_rd(d);
    ctrl_wr(ctrl_val(1, 0, 0, 0, 4'd3)); data_rd(d); chk("R12 ep3 first", d, 16'hC1C0);
    ctrl_wr(ctrl_val(1, 0, 0, 0, 4'd1));
    chk("R12 ep1 count kept", 16'(data_len), 16'd2);
    data_rd(d); chk("R12 ep1 pointer kept", d, 16'hA3A2);

    // R11: write to a receive buffer is ignored
    ctrl_wr(ctrl_val(1, 1, 0, 0, 4'd1));
    data_wr(16'hFFFF);
    chk("R11 out write len", 16'(data_len), 16'd4);
    side_peek(1, 0, b); chk("R11 out write mem", 16'(b), 16'h00A0);

    // R11 / R4 / R3 / R10: transmit buffer
    ctrl_wr(ctrl_val(0, 0, 0, 0, 4'd5));
    data_wr(16'hBBAA);
    side_peek(5, 0, b); chk("R4 write low lane", 16'(b), 16'h00AA);
    side_peek(5, 1, b); chk("R4 write high lane", 16'(b), 16'h00BB);
    chk("R11 in count", 16'(data_len), 16'd2);
    ctrl_wr(ctrl_val(0, 0, 1, 0, 4'd5));
    data_wr(16'h1122);
    side_peek(5, 2, b); chk("R4 swapped write", 16'(b), 16'h0011);
    ctrl_wr(ctrl_val(0, 0, 0, 1, 4'd5));
    data_wr(16'h9977);
    side_peek(5, 4, b); chk("R3 byte write", 16'(b), 16'h0077);
    chk("R3 byte count", 16'(data_len), 16'd5);
    data_rd(d); chk("R11 read from in", d, 16'h0);
    ctrl_wr(ctrl_val(0, 1, 0, 0, 4'd5));
    chk("R10 in rewind count", 16'(data_len), 16'd0);
    data_wr(16'hCDEF);
    side_peek(5, 0, b); chk("R10 write at start", 16'(b), 16'h00EF);
    for (int i = 0; i < 32; i++) data_wr(16'(i));
    chk("R11 full count", 16'(data_len), 16'd64);
    side_peek(5, 63, b);
    data_wr(16'h5A5A);
    chk("R11 full drop count", 16'(data_len), 16'd64);
    begin
      logic [7:0] b2;
      side_peek(5, 63, b2); chk("R11 full drop data", 16'(b2), 16'(b));
    end

    // Random drains of receive buffers: R3 R4 R5 R6 R7 R8
    for (int t = 0; t < 40; t++) begin
      int e, l, ptr, n, ec;
      bit oct, swp, rc;
      e = 1 + int'($urandom % 4);
      l = 1 + int'($urandom % 64);
      oct = $urandom % 2; swp = $urandom % 2; rc = $urandom % 2;
      if (t < 4) begin l = 2 * t + 1; oct = 0; end
      for (int i = 0; i < l; i++) side_byte(e, i, 8'($urandom));
      side_setlen(e, l);
      ctrl_wr(ctrl_val(rc, 0, swp, oct, 4'(e)));
      chk("R13 len", 16'(data_len), 16'(l));
      ptr = 0; ec = l;
      while (ptr < l) begin
        n = (oct || l - ptr == 1) ? 1 : 2;
        data_rd(d);
        if (oct) chk("R3 byte read", d, exp_word(e, ptr, l, oct, swp));
        else if (n == 1) chk("R7 tail byte", d, exp_word(e, ptr, l, oct, swp));
        else chk("R4 word read", d, exp_word(e, ptr, l, oct, swp));
        ptr += n;
        ec = rc ? ec - n : ((ptr >= l) ? 0 : l);
        if (rc) chk("R6 count step", 16'(data_len), 16'(ec));
        else chk("R5 count hold/clear", 16'(data_len), 16'(ec));
      end
      data_rd(d); chk("R8 empty read", d, 16'h0);
      chk("R8 empty len", 16'(data_len), 16'h0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule